// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Standby Wakeup

This block recovers characters from an asynchronous serial line. A frame holds one low start bit, then eight or nine data bits sent least significant bit first, then one high stop bit. The line is read through a two-flop synchronizer. It is sampled at the middle of each bit, using an enable that pulses sixteen times per bit period. When parity is on, the most significant character bit is the parity bit; it is not an extra bit. The block checks that bit against an even or odd rule. Each character is delivered with a one-cycle strobe and with parity and framing error flags.

The block also detects an idle line, meaning one full frame length of consecutive high bit times. The count of ones can start right after a start bit, or only once the stop bit has been sampled. A standby request puts the receiver to sleep, and while it sleeps it delivers nothing. It wakes either on an idle line or on a character whose most significant bit is 1 (an address mark). Which of the two applies is set by configuration.

The state machine has five states:

- IDLE goes to START on a low line.
- START goes to DATA when the line is still low at mid start bit, or back to IDLE when it is high.
- DATA goes to DATA for each further bit, and to STOP after the last data bit.
- STOP goes to IDLE when the stop bit is sampled high, or to WAIT_HIGH when it is sampled low.
- WAIT_HIGH goes to IDLE once the line is high again.

Top module: `uart_wake_rx`

## Requirements
- R1: Bits are received least significant first. With `cfg_nine`=0 the character is 8 bits, placed in `rx_data[7:0]` with `rx_data[8]`=0. With `cfg_nine`=1 it is 9 bits in `rx_data[8:0]`.
- R2: A low pulse on `rxd` shorter than half a bit period is not taken as a start bit, and no character results from it.
- R3: `rx_valid` is a one-cycle pulse per delivered character. `rx_data`, `par_err` and `frm_err` change only in a cycle where `rx_valid` is 1.
- R4: With `cfg_par_en`=1, `par_err` is 1 when the number of ones in the whole character (parity bit included) is odd for `cfg_par_odd`=0, or even for `cfg_par_odd`=1. With `cfg_par_en`=0, `par_err` is 0.
- R5: A stop bit sampled low sets `frm_err` and still delivers the data. The receiver then ignores the line until it has returned high.
- R6: `idle_flag` pulses for one cycle after 10 (8-bit) or 11 (9-bit) consecutive high bit times. It fires once per idle period and is re-armed by any low level on the line.
- R7: With `cfg_idle_after_stop`=0, ones are counted from the end of the start bit. An all-ones character followed by a two-bit gap therefore raises `idle_flag` before the next frame. With `cfg_idle_after_stop`=1, counting starts at the stop sample, and the same traffic raises no `idle_flag`.
- R8: `standby_req` sets `standby` on the next cycle. While in standby, received characters raise no `rx_valid`, and `rx_data` and the flags hold their values.
- R9: With `cfg_wake_addr`=0, an `idle_flag` pulse during standby clears `standby`.
- R10: With `cfg_wake_addr`=1, a character whose most significant bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is 1 clears `standby` and is delivered. A character with that bit 0 is dropped. Idle has no effect on standby in this mode.
- R11: After reset `standby`, `rx_valid`, `par_err`, `frm_err`, `idle_flag` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial input line, idle high |
| cfg_nine | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_wake_addr | input | 1 | 1 = address-mark wakeup, 0 = idle wakeup |
| cfg_idle_after_stop | input | 1 | 1 = idle count starts at stop sample, 0 = after start bit |
| standby_req | input | 1 | Pulse to enter standby |
| rx_data | output | 9 | Last delivered character |
| rx_valid | output | 1 | One-cycle strobe for a delivered character |
| par_err | output | 1 | Parity error of the last delivered character |
| frm_err | output | 1 | Framing error of the last delivered character |
| idle_flag | output | 1 | One-cycle pulse when an idle line is detected |
| standby | output | 1 | Receiver is in standby |

## Verification
`rx_valid` comes one clock after the stop sample. That is about 2 clocks of synchronizer delay plus 8 + 16·(N+1) ticks after the falling start edge, where N is the character length. The scoreboard monitor therefore waits on the strobe and does not count cycles. `standby` follows `standby_req` by one clock and is sampled on the next falling edge. `idle_flag` and the idle wakeup come one frame length of ticks after counting begins. Those checks look at windows placed at least one bit time before and after the due point, so that synchronizer latency cannot move a result across a check.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP,
        S_WAIT_HIGH
    } rx_state_t;

    localparam int CHAR_W = 9;
endpackage

// File: rtl/rxw_frame_fsm.sv
module rxw_frame_fsm
    import rxw_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_s,
    input  logic              cfg_nine,
    output rx_state_t         state,
    output logic              done,
    output logic [CHAR_W-1:0] chr,
    output logic              stop_ok
);
    localparam int CW = (OS > 2) ? $clog2(OS) : 1;
    localparam logic [CW-1:0] MID  = CW'(OS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS - 1);

    rx_state_t     nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [3:0]    idx, idx_nxt;
    logic [3:0]    last_idx;
    logic          take_bit, take_stop, start_ok;

    assign last_idx = cfg_nine ? 4'd8 : 4'd7;

    // next-state and counter logic
    always_comb begin
        nxt       = state;
        cnt_nxt   = cnt;
        idx_nxt   = idx;
        take_bit  = 1'b0;
        take_stop = 1'b0;
        start_ok  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (!rx_s) begin
                    nxt     = S_START;
                    cnt_nxt = '0;
                end
            end
            S_START: begin
                if (os_tick) begin
                    if (cnt == MID) begin
                        cnt_nxt = '0;
                        idx_nxt = '0;
                        if (!rx_s) begin
                            nxt      = S_DATA;
                            start_ok = 1'b1;
                        end else begin
                            nxt = S_IDLE;
                        end
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (os_tick) begin
                    if (cnt == LAST) begin
                        cnt_nxt  = '0;
                        take_bit = 1'b1;
                        if (idx == last_idx) nxt = S_STOP;
                        else idx_nxt = idx + 4'd1;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            S_STOP: begin
                if (os_tick) begin
                    if (cnt == LAST) begin
                        cnt_nxt   = '0;
                        take_stop = 1'b1;
                        nxt       = rx_s ? S_IDLE : S_WAIT_HIGH;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            S_WAIT_HIGH: begin
                if (rx_s) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            idx   <= idx_nxt;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            chr     <= '0;
            stop_ok <= 1'b0;
        end else begin
            done <= take_stop;
            if (start_ok) chr <= '0;
            else if (take_bit) chr[idx] <= rx_s;
            if (take_stop) stop_ok <= rx_s;
        end
    end
endmodule

// File: rtl/rxw_idle_det.sv
module rxw_idle_det #(
    parameter int OS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rx_s,
    input  logic cfg_nine,
    input  logic cfg_after_stop,
    input  logic line_quiet,
    output logic idle_pulse
);
    localparam int IW = $clog2(11 * OS + 1);
    localparam logic [IW-1:0] TH8 = IW'(10 * OS);
    localparam logic [IW-1:0] TH9 = IW'(11 * OS);

    logic [IW-1:0] ones_cnt;
    logic [IW-1:0] thresh;
    logic          en, hit, armed;

    assign thresh = cfg_nine ? TH9 : TH8;
    assign en     = cfg_after_stop ? line_quiet : 1'b1;
    assign hit    = en && rx_s && os_tick && (ones_cnt == thresh - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_cnt   <= '0;
            armed      <= 1'b1;
            idle_pulse <= 1'b0;
        end else begin
            if (!rx_s || !en) ones_cnt <= '0;
            else if (os_tick && ones_cnt < thresh) ones_cnt <= ones_cnt + 1'b1;

            if (!rx_s) armed <= 1'b1;
            else if (hit) armed <= 1'b0;

            idle_pulse <= hit && armed;
        end
    end
endmodule

// File: rtl/rxw_standby.sv
module rxw_standby (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_req,
    input  logic cfg_wake_addr,
    input  logic idle_pulse,
    input  logic char_done,
    input  logic char_msb,
    output logic standby
);
    logic wake;

    assign wake = cfg_wake_addr ? (char_done && char_msb) : idle_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) standby <= 1'b0;
        else if (standby_req) standby <= 1'b1;
        else if (standby && wake) standby <= 1'b0;
    end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import rxw_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       cfg_nine,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_wake_addr,
    input  logic       cfg_idle_after_stop,
    input  logic       standby_req,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       par_err,
    output logic       frm_err,
    output logic       idle_flag,
    output logic       standby
);
    logic              rx_meta, rx_s;
    rx_state_t         fsm_state;
    logic              done, stop_ok;
    logic [CHAR_W-1:0] chr, chr_m;
    logic              msb, deliver, par_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rxd;
            rx_s    <= rx_meta;
        end
    end

    rxw_frame_fsm #(.OS(OS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rx_s    (rx_s),
        .cfg_nine(cfg_nine),
        .state   (fsm_state),
        .done    (done),
        .chr     (chr),
        .stop_ok (stop_ok)
    );

    rxw_idle_det #(.OS(OS)) u_idle (
        .clk           (clk),
        .rst_n         (rst_n),
        .os_tick       (os_tick),
        .rx_s          (rx_s),
        .cfg_nine      (cfg_nine),
        .cfg_after_stop(cfg_idle_after_stop),
        .line_quiet    (fsm_state == S_IDLE),
        .idle_pulse    (idle_flag)
    );

    assign chr_m   = cfg_nine ? chr : {1'b0, chr[7:0]};
    assign msb     = cfg_nine ? chr[8] : chr[7];
    assign par_bad = cfg_par_en && ((^chr_m) ^ cfg_par_odd);
    assign deliver = done && (!standby || (cfg_wake_addr && msb));

    rxw_standby u_sby (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_req  (standby_req),
        .cfg_wake_addr(cfg_wake_addr),
        .idle_pulse   (idle_flag),
        .char_done    (done),
        .char_msb     (msb),
        .standby      (standby)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            rx_valid <= deliver;
            if (deliver) begin
                rx_data <= chr_m;
                par_err <= par_bad;
                frm_err <= !stop_ok;
            end
        end
    end
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_nine,
    input logic       cfg_par_en,
    input logic       cfg_wake_addr,
    input logic       standby_req,
    input logic [8:0] rx_data,
    input logic       rx_valid,
    input logic       par_err,
    input logic       frm_err,
    input logic       idle_flag,
    input logic       standby
);
    assert_nine_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !cfg_nine |-> rx_data[8] == 1'b0);

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rx_data) || !$stable(par_err) || !$stable(frm_err)) |-> rx_valid);

    assert_no_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !cfg_par_en |-> !par_err);

    assert_idle_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_flag |=> !idle_flag);

    assert_enter_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby_req |=> standby);

    assert_idle_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        standby && idle_flag && !cfg_wake_addr && !standby_req |=> !standby);

    assert_wake_char_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && $past(standby) |-> cfg_wake_addr && (cfg_nine ? rx_data[8] : rx_data[7]));
endmodule

bind uart_wake_rx rxw_checker u_chk (.*);

// File: tb/tb_uart_wake_rx.sv
module tb_uart_wake_rx;
    localparam int BIT = 32;   // clocks per bit: 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_wake_addr = 1'b0, cfg_idle_after_stop = 1'b1;
    logic       standby_req = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, par_err, frm_err, idle_flag, standby;

    int n_tests = 0, n_fail = 0;
    int valid_cnt = 0, idle_cnt = 0;
    logic [10:0] expq[$];
    string       tagq[$];
    logic [8:0]  last_data = '0;

    always #5 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    uart_wake_rx dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n && idle_flag) idle_cnt++;
        if (rst_n && rx_valid) begin
            valid_cnt++;
            if (expq.size() == 0) begin
                check(0, "R8 unexpected character", int'(rx_data), 0);
            end else begin
                logic [10:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check({frm_err, par_err, rx_data} == e, t, int'({frm_err, par_err, rx_data}), int'(e));
            end
            last_data = rx_data;
        end
    end

    function automatic logic exp_par(input logic [8:0] d);
        logic [8:0] m;
        m = cfg_nine ? d : {1'b0, d[7:0]};
        return cfg_par_en && ((^m) ^ cfg_par_odd);
    endfunction

    task automatic wait_bits(input int n);
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input logic stop, input int gap,
                        input bit expect_it, input string tag);
        int nb;
        nb = cfg_nine ? 9 : 8;
        if (expect_it) begin
            expq.push_back({~stop, exp_par(d), (cfg_nine ? d : {1'b0, d[7:0]})});
            tagq.push_back(tag);
        end
        rxd = 1'b0;
        wait_bits(1);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            wait_bits(1);
        end
        rxd = stop;
        wait_bits(1);
        rxd = 1'b1;
        wait_bits(gap);
    endtask

    task automatic pulse_standby();
        standby_req = 1'b1;
        @(negedge clk);
        standby_req = 1'b0;
        check(standby == 1'b1, "R8 standby set", standby, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int v0, i0;
        repeat (3) @(negedge clk);
        check({rx_data, rx_valid, par_err, frm_err, idle_flag, standby} == '0, "R11 reset state",
              int'({rx_data, rx_valid, par_err, frm_err, idle_flag, standby}), 0);
        rst_n = 1'b1;

        // R6: idle after reset, 10 bit times of high line
        wait_bits(9);
        check(idle_cnt == 0, "R6 no idle before 10 bits", idle_cnt, 0);
        wait_bits(2);
        check(idle_cnt == 1, "R6 idle after 10 bits", idle_cnt, 1);

        // R1: 8-bit characters
        send(9'h055, 1, 2, 1, "R1 8-bit 55");
        send(9'h0A3, 1, 2, 1, "R1 8-bit A3");
        send(9'h000, 1, 2, 1, "R1 8-bit 00");
        send(9'h0FF, 1, 2, 1, "R1 8-bit FF");
        // R1: 9-bit characters
        cfg_nine = 1'b1;
        send(9'h1A5, 1, 2, 1, "R1 9-bit 1A5");
        send(9'h0F0, 1, 2, 1, "R1 9-bit 0F0");

        // R6: 9-bit idle needs 11 bit times counted from the stop sample
        i0 = idle_cnt;
        send(9'h13C, 1, 0, 1, "R1 9-bit 13C");
        wait_bits(9);
        check(idle_cnt == i0, "R6 no 9-bit idle early", idle_cnt, i0);
        wait_bits(2);
        check(idle_cnt == i0 + 1, "R6 9-bit idle", idle_cnt, i0 + 1);

        // R4: parity in MSB position, even and odd
        cfg_par_en = 1'b1;
        cfg_nine = 1'b0;
        send(9'h003, 1, 2, 1, "R4 even ok");
        send(9'h083, 1, 2, 1, "R4 even bad");
        cfg_par_odd = 1'b1;
        send(9'h083, 1, 2, 1, "R4 odd ok");
        send(9'h003, 1, 2, 1, "R4 odd bad");
        cfg_nine = 1'b1;
        cfg_par_odd = 1'b0;
        send(9'h101, 1, 2, 1, "R4 9-bit even ok");
        send(9'h1FF, 1, 2, 1, "R4 9-bit even bad");
        cfg_par_en = 1'b0;
        cfg_nine = 1'b0;

        // R5: low stop bit, data still delivered, then normal frame
        send(9'h03C, 0, 3, 1, "R5 framing error");
        send(9'h03C, 1, 2, 1, "R5 recovery");

        // R2: short low glitch is not a start bit
        v0 = valid_cnt;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        wait_bits(24);
        check(valid_cnt == v0, "R2 glitch rejected", valid_cnt, v0);
        send(9'h066, 1, 12, 1, "R2 frame after glitch");

        // R7: idle count start point
        cfg_idle_after_stop = 1'b0;
        i0 = idle_cnt;
        send(9'h0FF, 1, 2, 1, "R7 after-start FF");
        check(idle_cnt == i0 + 1, "R7 after-start false idle", idle_cnt, i0 + 1);
        send(9'h011, 1, 12, 1, "R7 after-start next");
        cfg_idle_after_stop = 1'b1;
        i0 = idle_cnt;
        send(9'h0FF, 1, 2, 1, "R7 after-stop FF");
        check(idle_cnt == i0, "R7 after-stop no idle", idle_cnt, i0);
        send(9'h011, 1, 12, 1, "R7 after-stop next");

        // R8/R9: standby with idle wakeup
        cfg_wake_addr = 1'b0;
        pulse_standby();
        v0 = valid_cnt;
        send(9'h012, 1, 2, 0, "");
        send(9'h0B4, 1, 2, 0, "");
        check(valid_cnt == v0, "R8 no delivery in standby", valid_cnt, v0);
        check(rx_data == last_data, "R8 data held in standby", int'(rx_data), int'(last_data));
        check(standby == 1'b1, "R9 still asleep before idle", standby, 1);
        wait_bits(12);
        check(standby == 1'b0, "R9 idle wakeup", standby, 0);
        send(9'h05A, 1, 12, 1, "R9 delivery after wake");

        // R10: address-mark wakeup, 8-bit
        cfg_wake_addr = 1'b1;
        pulse_standby();
        v0 = valid_cnt;
        send(9'h021, 1, 12, 0, "");
        check(valid_cnt == v0, "R10 non-address dropped", valid_cnt, v0);
        check(standby == 1'b1, "R10 idle does not wake", standby, 1);
        send(9'h0A1, 1, 2, 1, "R10 address char delivered");
        check(standby == 1'b0, "R10 address wakeup", standby, 0);

        // R10: address-mark wakeup, 9-bit
        cfg_nine = 1'b1;
        pulse_standby();
        v0 = valid_cnt;
        send(9'h0FF, 1, 2, 0, "");
        check(valid_cnt == v0, "R10 9-bit non-address dropped", valid_cnt, v0);
        send(9'h101, 1, 4, 1, "R10 9-bit address delivered");
        check(standby == 1'b0, "R10 9-bit address wakeup", standby, 0);

        wait_bits(2);
        check(expq.size() == 0, "R1 all characters delivered", expq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule